// File: doc/BRIEF.md
# Iterative Parallel Ridge Thinning Unit

This block reduces the ridges of a binary fingerprint-style image to skeletons one pixel wide. The image sits in an external single-bit pixel memory that holds two image buffers. After a start pulse, the unit makes raster-order passes over the image. Each pass reads every pixel of one buffer once and writes the result into the other buffer. A register window spanning two image rows plus three pixels gives the full 3x3 neighbourhood of each centre pixel, and that neighbourhood decides whether the centre is kept or deleted.

Passes come in pairs that form one iteration, and each pass applies a different directional deletion rule. Iterations repeat until one of them deletes nothing. After that, two clean-up passes remove the corner pixels of staircase-shaped diagonal ridges. The number of passes is always even, so the finished image always ends up in buffer 0. The unit reports how many iterations it ran and pulses `done` when the result is complete.

Top module: `thin_unit`

## Requirements
- R1: A pixel value of 0 is ridge and 1 is background. The pixel at row r, column c has index r*IMG_W+c. The memory address is {buffer bit, index}, where the buffer bit is the most significant address bit, and the source image is loaded into buffer 0.
- R2: In the thinning passes, an interior ridge pixel is deleted (written as 1) only if all of the following hold. It has 2 to 6 ridge neighbours. Its neighbours, taken in the circular order N, NE, E, SE, S, SW, W, NW, contain exactly one background-to-ridge step. In the first pass of an iteration, N·E·S and E·S·W are both zero. In the second pass, N·E·W and N·S·W are both zero. The products are taken over ridge flags.
- R3: Deletions within a pass are parallel. Every decision uses the values from before the pass, because a pass reads one buffer and writes only the other.
- R4: Pixels in the first or last row or column are never changed.
- R5: Iterations repeat until an iteration whose two passes delete nothing. `iter_count` gives the number of iterations run, including that final one, and holds its value while the unit is idle.
- R6: After thinning, two clean-up passes run. The first deletes an interior ridge pixel whose ridge neighbours include N and E with NE, S, W and SW background, or N and W with NW, S, E and SE background. The second deletes an interior ridge pixel whose ridge neighbours include S and E with SE, N, W and NW background, or S and W with SW, N, E and NE background.
- R7: `busy` rises in the cycle after an accepted start. The final image is in buffer 0 when `done` pulses high for one cycle, and `busy` falls in that same cycle.
- R8: After reset, `busy`, `done`, `mem_rd_en` and `mem_wr_en` are low and `iter_count` is 0, and no memory access happens while the unit is idle.
- R9: A `start` pulse while `busy` is high has no effect on the run or its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin thinning the image in buffer 0 |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse when the result is in buffer 0 |
| iter_count | output | CNT_W | Thinning iterations of the last run |
| mem_rd_en | output | 1 | Pixel read request |
| mem_rd_addr | output | ADDR_W | Read address {buffer, index} |
| mem_rd_data | input | 1 | Read pixel, valid one cycle after the request |
| mem_wr_en | output | 1 | Pixel write strobe |
| mem_wr_addr | output | ADDR_W | Write address {buffer, index} |
| mem_wr_data | output | 1 | Pixel value written |

## Verification
The hardest situation to reach is one where the parallel rule matters. Here, a sequential in-place update would delete a different set of pixels than a decision based on the pre-pass image. A further difficulty is the clean-up stage, which only does anything on 4-connected diagonal staircases that survive thinning. The stimulus therefore loads filled blocks, thick bars and an explicit diagonal staircase into buffer 0. It also loads ridges that run along the image border and a pseudo-random pattern. Buffer 1 is filled with stale ridge pixels so that a pass that reads the wrong buffer shows up. A start pulse is injected in the middle of one run.

// File: rtl/thin_pkg.sv
package thin_pkg;
  typedef enum logic [1:0] {
    PASS_THIN_A  = 2'd0,
    PASS_THIN_B  = 2'd1,
    PASS_CLEAN_N = 2'd2,
    PASS_CLEAN_S = 2'd3
  } pass_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_DRAIN = 2'd2
  } state_e;
endpackage

// File: rtl/thin_window.sv
module thin_window #(
  parameter int IMG_W = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       shift_en,
  input  logic       bit_in,
  output logic       ctr,
  output logic [7:0] nb   // [0]=N [1]=NE [2]=E [3]=SE [4]=S [5]=SW [6]=W [7]=NW
);
  localparam int SR_LEN  = 2 * IMG_W + 2;
  localparam int WIN_LEN = SR_LEN + 1;

  logic [SR_LEN-1:0]  sr_q, sr_d;
  logic [WIN_LEN-1:0] win;

  // win[k] holds the pixel k positions before the newest one
  assign win = {sr_q, bit_in};

  always_comb begin
    sr_d = sr_q;
    if (shift_en) sr_d = win[SR_LEN-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '1;
    else        sr_q <= sr_d;
  end

  assign ctr   = win[IMG_W+1];
  assign nb[0] = win[2*IMG_W+1];
  assign nb[1] = win[2*IMG_W];
  assign nb[2] = win[IMG_W];
  assign nb[3] = win[0];
  assign nb[4] = win[1];
  assign nb[5] = win[2];
  assign nb[6] = win[IMG_W+2];
  assign nb[7] = win[2*IMG_W+2];
endmodule

// File: rtl/thin_rules.sv
module thin_rules
  import thin_pkg::*;
(
  input  pass_e      kind,
  input  logic       ctr,
  input  logic [7:0] nb,
  input  logic       border,
  output logic       del
);
  logic [7:0] rg;
  logic [3:0] n_ridge;
  logic [3:0] n_step;
  logic       rn, rne, re, rse, rs, rsw, rw, rnw;
  logic       core_ok, dir_ok, clean_ok;

  assign rg = ~nb;
  assign {rnw, rw, rsw, rs, rse, re, rne, rn} = rg;

  always_comb begin
    n_ridge = '0;
    n_step  = '0;
    for (int k = 0; k < 8; k++) begin
      n_ridge = n_ridge + 4'(rg[k]);
      if (!rg[k] && rg[(k + 1) % 8]) n_step = n_step + 4'd1;
    end
  end

  assign core_ok = (n_ridge >= 4'd2) && (n_ridge <= 4'd6) && (n_step == 4'd1);

  always_comb begin
    dir_ok   = 1'b0;
    clean_ok = 1'b0;
    case (kind)
      PASS_THIN_A:  dir_ok = !(rn && re && rs) && !(re && rs && rw);
      PASS_THIN_B:  dir_ok = !(rn && re && rw) && !(rn && rs && rw);
      PASS_CLEAN_N: clean_ok = (rn && re && !rne && !rs && !rw && !rsw) ||
                               (rn && rw && !rnw && !rs && !re && !rse);
      default:      clean_ok = (rs && re && !rse && !rn && !rw && !rnw) ||
                               (rs && rw && !rsw && !rn && !re && !rne);
    endcase
  end

  assign del = !border && !ctr &&
               (((kind == PASS_THIN_A) || (kind == PASS_THIN_B)) ? (core_ok && dir_ok) : clean_ok);
endmodule

// File: rtl/thin_ctrl.sv
module thin_ctrl
  import thin_pkg::*;
#(
  parameter int IMG_W = 256,
  parameter int IMG_H = 256,
  parameter int CNT_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   del,
  output logic                   busy,
  output logic                   done,
  output logic [CNT_W-1:0]       iter_count,
  output logic                   rd_en,
  output logic [$clog2(IMG_W*IMG_H):0] rd_addr,
  output logic                   win_shift,
  output logic                   win_from_mem,
  output logic                   wr_en,
  output logic [$clog2(IMG_W*IMG_H):0] wr_addr,
  output logic                   border,
  output pass_e                  kind
);
  localparam int NPIX   = IMG_W * IMG_H;
  localparam int PIX_AW = $clog2(NPIX);
  localparam int SCAN_W = $clog2(NPIX + IMG_W + 1);
  localparam int COL_W  = $clog2(IMG_W);
  localparam int ROW_W  = $clog2(IMG_H);
  localparam logic [SCAN_W-1:0] SCAN_LAST = SCAN_W'(NPIX + IMG_W);
  localparam logic [SCAN_W-1:0] SCAN_NPIX = SCAN_W'(NPIX);
  localparam logic [SCAN_W-1:0] SCAN_EMIT = SCAN_W'(IMG_W + 1);
  localparam logic [COL_W-1:0]  COL_LAST  = COL_W'(IMG_W - 1);
  localparam logic [ROW_W-1:0]  ROW_LAST  = ROW_W'(IMG_H - 1);

  state_e              state_q, state_d;
  pass_e               kind_q, kind_d;
  logic                src_q, src_d;
  logic [SCAN_W-1:0]   cnt_q, cnt_d;
  logic                v1_q, v1_d, inimg_q, inimg_d, emit_q, emit_d;
  logic [PIX_AW-1:0]   cidx_q, cidx_d;
  logic [COL_W-1:0]    ccol_q, ccol_d;
  logic [ROW_W-1:0]    crow_q, crow_d;
  logic                chg_q, chg_d, chg_any;
  logic [CNT_W-1:0]    iter_q, iter_d;
  logic                done_q, done_d;

  assign wr_en   = v1_q && emit_q;
  assign chg_any = chg_q || (wr_en && del);

  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    src_d   = src_q;
    cnt_d   = cnt_q;
    cidx_d  = cidx_q;
    ccol_d  = ccol_q;
    crow_d  = crow_q;
    chg_d   = chg_any;
    iter_d  = iter_q;
    done_d  = 1'b0;
    v1_d    = 1'b0;
    inimg_d = 1'b0;
    emit_d  = 1'b0;

    if (wr_en) begin
      cidx_d = cidx_q + 1'b1;
      if (ccol_q == COL_LAST) begin
        ccol_d = '0;
        crow_d = crow_q + 1'b1;
      end else begin
        ccol_d = ccol_q + 1'b1;
      end
    end

    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_SCAN;
          kind_d  = PASS_THIN_A;
          src_d   = 1'b0;
          cnt_d   = '0;
          cidx_d  = '0;
          ccol_d  = '0;
          crow_d  = '0;
          chg_d   = 1'b0;
          iter_d  = '0;
        end
      end
      ST_SCAN: begin
        v1_d    = 1'b1;
        inimg_d = cnt_q < SCAN_NPIX;
        emit_d  = cnt_q >= SCAN_EMIT;
        cnt_d   = cnt_q + 1'b1;
        if (cnt_q == SCAN_LAST) state_d = ST_DRAIN;
      end
      default: begin
        state_d = ST_SCAN;
        src_d   = !src_q;
        cnt_d   = '0;
        cidx_d  = '0;
        ccol_d  = '0;
        crow_d  = '0;
        case (kind_q)
          PASS_THIN_A: kind_d = PASS_THIN_B;
          PASS_THIN_B: begin
            iter_d = iter_q + 1'b1;
            if (chg_any) begin
              kind_d = PASS_THIN_A;
              chg_d  = 1'b0;
            end else begin
              kind_d = PASS_CLEAN_N;
            end
          end
          PASS_CLEAN_N: kind_d = PASS_CLEAN_S;
          default: begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end
        endcase
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= PASS_THIN_A;
      src_q   <= 1'b0;
      cnt_q   <= '0;
      v1_q    <= 1'b0;
      inimg_q <= 1'b0;
      emit_q  <= 1'b0;
      cidx_q  <= '0;
      ccol_q  <= '0;
      crow_q  <= '0;
      chg_q   <= 1'b0;
      iter_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      src_q   <= src_d;
      cnt_q   <= cnt_d;
      v1_q    <= v1_d;
      inimg_q <= inimg_d;
      emit_q  <= emit_d;
      cidx_q  <= cidx_d;
      ccol_q  <= ccol_d;
      crow_q  <= crow_d;
      chg_q   <= chg_d;
      iter_q  <= iter_d;
      done_q  <= done_d;
    end
  end

  assign busy         = (state_q != ST_IDLE);
  assign done         = done_q;
  assign iter_count   = iter_q;
  assign rd_en        = (state_q == ST_SCAN) && (cnt_q < SCAN_NPIX);
  assign rd_addr      = {src_q, cnt_q[PIX_AW-1:0]};
  assign win_shift    = v1_q;
  assign win_from_mem = inimg_q;
  assign wr_addr      = {!src_q, cidx_q};
  assign border       = (ccol_q == '0) || (ccol_q == COL_LAST) ||
                        (crow_q == '0) || (crow_q == ROW_LAST);
  assign kind         = kind_q;
endmodule

// File: rtl/thin_unit.sv
module thin_unit
  import thin_pkg::*;
#(
  parameter int IMG_W = 256,
  parameter int IMG_H = 256,
  parameter int CNT_W = 8,
  localparam int ADDR_W = $clog2(IMG_W * IMG_H) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic [CNT_W-1:0]  iter_count,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_data,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic              mem_wr_data
);
  logic       win_shift, win_from_mem, ctr, border, del;
  logic [7:0] nb;
  pass_e      kind;

  thin_ctrl #(.IMG_W(IMG_W), .IMG_H(IMG_H), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .del(del),
    .busy(busy), .done(done), .iter_count(iter_count),
    .rd_en(mem_rd_en), .rd_addr(mem_rd_addr),
    .win_shift(win_shift), .win_from_mem(win_from_mem),
    .wr_en(mem_wr_en), .wr_addr(mem_wr_addr),
    .border(border), .kind(kind)
  );

  thin_window #(.IMG_W(IMG_W)) u_win (
    .clk(clk), .rst_n(rst_n), .shift_en(win_shift),
    .bit_in(win_from_mem ? mem_rd_data : 1'b1),
    .ctr(ctr), .nb(nb)
  );

  thin_rules u_rules (
    .kind(kind), .ctr(ctr), .nb(nb), .border(border), .del(del)
  );

  assign mem_wr_data = ctr | del;
endmodule

// File: rtl/thin_unit_chk.sv
module thin_unit_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [CNT_W-1:0] iter_count,
  input logic             mem_rd_en,
  input logic             rd_buf,
  input logic             mem_wr_en,
  input logic             wr_buf
);
  a_r8_idle_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd_en && !mem_wr_en));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_busy_fall_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r3_split_buffers: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && mem_wr_en) |-> (rd_buf != wr_buf));

  a_r9_run_continues: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));

  a_r5_count_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(iter_count));
endmodule

bind thin_unit thin_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .iter_count(iter_count), .mem_rd_en(mem_rd_en),
  .rd_buf(mem_rd_addr[ADDR_W-1]), .mem_wr_en(mem_wr_en),
  .wr_buf(mem_wr_addr[ADDR_W-1])
);

// File: tb/thin_unit_tb.sv
`timescale 1ns/1ps
module thin_unit_tb;
  localparam int W     = 10;
  localparam int H     = 8;
  localparam int N     = W * H;
  localparam int CW    = 8;
  localparam int AW    = $clog2(N) + 1;
  localparam int BUF1  = 1 << (AW - 1);

  logic clk = 1'b0;
  logic rst_n;
  logic start;
  logic busy, done;
  logic [CW-1:0] iter_count;
  logic mem_rd_en, mem_rd_data, mem_wr_en, mem_wr_data;
  logic [AW-1:0] mem_rd_addr, mem_wr_addr;

  logic mem [0:(1<<AW)-1];

  int n_chk = 0;
  int n_fail = 0;

  logic [N-1:0] exp_img_q[$];
  logic [N-1:0] org_img_q[$];
  int           exp_it_q[$];

  always #2 clk = ~clk;

  thin_unit #(.IMG_W(W), .IMG_H(H), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .iter_count(iter_count), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data)
  );

  always @(posedge clk) begin
    if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];
    if (mem_wr_en) mem[mem_wr_addr] <= mem_wr_data;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic ridge(input logic [N-1:0] im, input int r, input int c);
    return !im[r*W+c];
  endfunction

  // kind: 0/1 thinning passes, 2/3 clean-up passes
  function automatic logic [N-1:0] ref_pass(input logic [N-1:0] im, input int kind);
    logic [N-1:0] o;
    o = im;
    for (int r = 1; r < H - 1; r++) begin
      for (int c = 1; c < W - 1; c++) begin
        logic n, ne, e, se, s, sw, wv, nw, d;
        logic [7:0] ring;
        int cnt, tr;
        n  = ridge(im, r-1, c);   ne = ridge(im, r-1, c+1);
        e  = ridge(im, r, c+1);   se = ridge(im, r+1, c+1);
        s  = ridge(im, r+1, c);   sw = ridge(im, r+1, c-1);
        wv = ridge(im, r, c-1);   nw = ridge(im, r-1, c-1);
        ring = {nw, wv, sw, s, se, e, ne, n};
        cnt = 0; tr = 0;
        for (int k = 0; k < 8; k++) begin
          cnt += int'(ring[k]);
          if (!ring[k] && ring[(k+1)%8]) tr++;
        end
        d = 1'b0;
        if (kind == 0)
          d = cnt >= 2 && cnt <= 6 && tr == 1 && !(n && e && s) && !(e && s && wv);
        else if (kind == 1)
          d = cnt >= 2 && cnt <= 6 && tr == 1 && !(n && e && wv) && !(n && s && wv);
        else if (kind == 2)
          d = (n && e && !ne && !s && !wv && !sw) || (n && wv && !nw && !s && !e && !se);
        else
          d = (s && e && !se && !n && !wv && !nw) || (s && wv && !sw && !n && !e && !ne);
        if (ridge(im, r, c) && d) o[r*W+c] = 1'b1;
      end
    end
    return o;
  endfunction

  task automatic run_case(input logic [N-1:0] img, input string name, input bit poke);
    logic [N-1:0] cur, nxt;
    int it;
    cur = img; it = 0;
    do begin
      nxt = ref_pass(ref_pass(cur, 0), 1);
      it++;
      if (nxt == cur) break;
      cur = nxt;
    end while (1);
    cur = ref_pass(ref_pass(cur, 2), 3);
    exp_img_q.push_back(cur);
    org_img_q.push_back(img);
    exp_it_q.push_back(it);
    for (int i = 0; i < N; i++) begin
      mem[i] = img[i];
      mem[BUF1 + i] = 1'b0;   // stale ridge content in buffer 1
    end
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy == 1'b1, "R7", {name, " busy after start"}, 128'(busy), 128'(1));
    if (poke) begin
      repeat (30) @(negedge clk);
      start = 1'b1;           // R9: start while busy
      @(negedge clk); start = 1'b0;
    end
    do @(negedge clk); while (!done);
    repeat (3) @(negedge clk);
    check(!busy && iter_count == CW'(it), "R5", {name, " idle count held"},
          128'(iter_count), 128'(it));
  endtask

  // monitor: scoreboard compare on completion
  always @(negedge clk) begin
    if (rst_n && done) begin
      logic [N-1:0] got, ex, og;
      int eit;
      bit bord_ok;
      ex = exp_img_q.pop_front();
      og = org_img_q.pop_front();
      eit = exp_it_q.pop_front();
      for (int i = 0; i < N; i++) got[i] = mem[i];
      check(got == ex, "R2/R6 R1 R3", "result image in buffer 0", 128'(got), 128'(ex));
      check(iter_count == CW'(eit), "R5", "iteration count", 128'(iter_count), 128'(eit));
      bord_ok = 1'b1;
      for (int r = 0; r < H; r++)
        for (int c = 0; c < W; c++)
          if ((r == 0 || r == H-1 || c == 0 || c == W-1) && got[r*W+c] != og[r*W+c])
            bord_ok = 1'b0;
      check(bord_ok, "R4", "border pixels unchanged", 128'(got), 128'(og));
    end
  end

  function automatic logic [N-1:0] rect(input int r0, input int r1, input int c0, input int c1);
    logic [N-1:0] im;
    im = '1;
    for (int r = r0; r <= r1; r++)
      for (int c = c0; c <= c1; c++) im[r*W+c] = 1'b0;
    return im;
  endfunction

  initial begin
    int wd;
    for (wd = 0; wd < 150000; wd++) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [N-1:0] im;
    logic [15:0] lf;
    start = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R8 reset state
    check(!busy && !done, "R8", "busy/done after reset", 128'({busy, done}), 128'(0));
    check(!mem_rd_en && !mem_wr_en, "R8", "memory idle after reset",
          128'({mem_rd_en, mem_wr_en}), 128'(0));
    check(iter_count == '0, "R8", "count after reset", 128'(iter_count), 128'(0));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_case('1, "empty", 1'b0);
    run_case(rect(2, 4, 1, 8), "bar", 1'b0);
    run_case(rect(1, 6, 2, 7), "block", 1'b1);  // R9 start poked mid-run
    im = '1;                                    // R6 staircase
    for (int k = 1; k <= 6; k++) begin
      im[k*W+k] = 1'b0;
      if (k < 7) im[k*W+k+1] = 1'b0;
    end
    run_case(im, "stair", 1'b0);
    im = rect(0, 3, 0, 2);                      // R4 ridges on border
    for (int c = 0; c < W; c++) im[c] = 1'b0;
    run_case(im, "border", 1'b0);
    lf = 16'hACE1;
    for (int i = 0; i < N; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      im[i] = lf[0] & lf[3];
    end
    run_case(im, "random", 1'b0);

    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule